// File: doc/BRIEF.md
# DMA Looping Address Generator

This block produces the byte address used on each beat of a DMA copy, one for the read side and one for the write side. When a transfer begins, the two base addresses and a mode word are captured together. After that, each beat strobe moves both addresses forward by one byte in the same cycle.

Each side can run in one of two ways, chosen independently:

- **Linear:** the address keeps counting up for the whole transfer.
- **Hold (wrap):** the address moves through a small power-of-two window starting at the captured base, then returns to the base and repeats. This suits FIFO ports and device registers.

The window size is held in the mode word as a 2-bit log2 code, so a window of 1, 2, 4 or 8 bytes is possible. A window of 1 pins the address to the base.

Top module: `lag_top`

## Requirements
- R1: While `rst` is high at a clock edge, both address outputs read zero after that edge. The mode captured by reset is linear on both sides with zero offset.
- R2: A cycle with `start` high loads `src_base`, `dst_base` and `mode_word`, and clears both offsets. From the next cycle each address output equals its base. `start` takes priority over `advance` in the same cycle.
- R3: On a side whose hold-enable bit is clear, each `advance` adds one to that side's address, wrapping modulo 2^ADDR_W. The hold-enable bits are `mode_word[10]` for the source side and `mode_word[11]` for the destination side.
- R4: On a side whose hold-enable bit is set, the offset from the base steps 0, 1, …, 2^c−1 and then returns to 0. Here c is that side's window code: `mode_word[15:14]` for the source side and `mode_word[17:16]` for the destination side.
- R5: With hold enabled and a window code of 0, the address stays at its base on every `advance`.
- R6: A cycle with neither `start` nor `advance` leaves both addresses unchanged.
- R7: Each side follows only its own enable bit and window code. A mode that differs between the sides gives each side its own sequence.
- R8: The mode and the bases act only when they are captured at `start`. Changing `mode_word`, `src_base` or `dst_base` between starts has no effect on the outputs.
- R9: One `advance` steps both sides in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer: capture the bases and the mode, clear the offsets |
| advance | input | 1 | Beat strobe that moves both addresses |
| src_base | input | ADDR_W | Source base address |
| dst_base | input | ADDR_W | Destination base address |
| mode_word | input | 32 | Mode word carrying the per-side hold enables and window codes |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |

## Verification
Each output is the captured base plus an offset register, with no register after the adder. A corrupted offset or a wrong wrap mask therefore shows on the address in the very cycle after the faulty beat.

A wrong mode capture stays hidden until the first `advance` on the affected side. A window error needs as many beats as the window holds before it shows, at most 8.

The bench runs every window code on each side, linear wrap past the top of the address space, and mode changes between starts. It compares the outputs with a reference model every cycle.

// File: rtl/lag_pkg.sv
package lag_pkg;

    localparam int MODE_W       = 32;
    localparam int CODE_W       = 2;
    localparam int WIN_W        = 3;
    localparam int NUM_SIDES    = 2;
    localparam int SRC_EN_BIT   = 10;
    localparam int DST_EN_BIT   = 11;
    localparam int SRC_CODE_LSB = 14;
    localparam int DST_CODE_LSB = 16;

    typedef enum logic {
        SIDE_SRC = 1'b0,
        SIDE_DST = 1'b1
    } side_e;

    typedef struct packed {
        logic              hold;
        logic [CODE_W-1:0] code;
    } side_mode_t;

    function automatic side_mode_t pick_side(input logic [MODE_W-1:0] mw,
                                             input side_e side);
        side_mode_t r;
        if (side == SIDE_SRC) begin
            r.hold = mw[SRC_EN_BIT];
            r.code = mw[SRC_CODE_LSB +: CODE_W];
        end else begin
            r.hold = mw[DST_EN_BIT];
            r.code = mw[DST_CODE_LSB +: CODE_W];
        end
        return r;
    endfunction

    function automatic logic [WIN_W-1:0] win_mask(input logic [CODE_W-1:0] code);
        logic [WIN_W:0] one_hot;
        one_hot = (WIN_W+1)'(1) << code;
        return WIN_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/lag_mode_decode.sv
module lag_mode_decode
    import lag_pkg::*;
(
    input  logic [MODE_W-1:0]                mode_word,
    output side_mode_t [NUM_SIDES-1:0]       cfg
);

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        localparam side_e SIDE = (g == 0) ? SIDE_SRC : SIDE_DST;
        always_comb cfg[g] = pick_side(mode_word, SIDE);
    end

endmodule

// File: rtl/lag_side.sv
module lag_side
    import lag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base_in,
    input  side_mode_t        cfg_in,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] off_q;
    logic [ADDR_W-1:0] off_inc;
    logic [ADDR_W-1:0] off_nxt;
    side_mode_t        cfg_q;

    always_comb begin
        off_inc = off_q + 1'b1;
        if (cfg_q.hold)
            off_nxt = off_inc & ADDR_W'(win_mask(cfg_q.code));
        else
            off_nxt = off_inc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            off_q  <= '0;
            cfg_q  <= '0;
        end else if (start) begin
            base_q <= base_in;
            off_q  <= '0;
            cfg_q  <= cfg_in;
        end else if (advance) begin
            off_q  <= off_nxt;
        end
    end

    assign addr = base_q + off_q;

endmodule

// File: rtl/lag_top.sv
module lag_top
    import lag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              advance,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [31:0]       mode_word,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    side_mode_t [NUM_SIDES-1:0]              cfg;
    logic       [NUM_SIDES-1:0][ADDR_W-1:0]  base_v;
    logic       [NUM_SIDES-1:0][ADDR_W-1:0]  addr_v;

    lag_mode_decode u_decode (
        .mode_word (mode_word),
        .cfg       (cfg)
    );

    assign base_v[SIDE_SRC] = src_base;
    assign base_v[SIDE_DST] = dst_base;

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        lag_side #(.ADDR_W(ADDR_W)) u_side (
            .clk     (clk),
            .rst     (rst),
            .start   (start),
            .advance (advance),
            .base_in (base_v[g]),
            .cfg_in  (cfg[g]),
            .addr    (addr_v[g])
        );
    end

    assign src_addr = addr_v[SIDE_SRC];
    assign dst_addr = addr_v[SIDE_DST];

endmodule

// File: rtl/lag_checker.sv
module lag_checker
    import lag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              advance,
    input logic [ADDR_W-1:0] src_base,
    input logic [ADDR_W-1:0] dst_base,
    input logic [31:0]       mode_word,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr
);

    logic              rst_q;
    logic [31:0]       cap_mode;
    logic [ADDR_W-1:0] cap_sb;
    logic [ADDR_W-1:0] cap_db;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            cap_mode <= '0;
            cap_sb   <= '0;
            cap_db   <= '0;
        end else if (start) begin
            cap_mode <= mode_word;
            cap_sb   <= src_base;
            cap_db   <= dst_base;
        end
    end

    // R1: outputs are zero right after a reset edge
    always @(posedge clk) begin
        if (rst_q === 1'b1 && rst === 1'b0)
            a_r1_reset_zero: assert (src_addr == '0 && dst_addr == '0);
    end

    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        start |=> (src_addr == $past(src_base)) && (dst_addr == $past(dst_base)));

    a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!start && !advance) |=> $stable(src_addr) && $stable(dst_addr));

    a_r3_src_linear: assert property (@(posedge clk) disable iff (rst)
        (!start && advance && !cap_mode[SRC_EN_BIT])
            |=> src_addr == $past(src_addr) + 1'b1);

    a_r3_dst_linear: assert property (@(posedge clk) disable iff (rst)
        (!start && advance && !cap_mode[DST_EN_BIT])
            |=> dst_addr == $past(dst_addr) + 1'b1);

    a_r4_src_window: assert property (@(posedge clk) disable iff (rst)
        (cap_mode[SRC_EN_BIT]) |->
            ADDR_W'(src_addr - cap_sb) < ADDR_W'(4'd1 << cap_mode[SRC_CODE_LSB +: CODE_W]));

    a_r4_dst_window: assert property (@(posedge clk) disable iff (rst)
        (cap_mode[DST_EN_BIT]) |->
            ADDR_W'(dst_addr - cap_db) < ADDR_W'(4'd1 << cap_mode[DST_CODE_LSB +: CODE_W]));

endmodule

bind lag_top lag_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_lag_top.sv
`timescale 1ns/1ps
module tb_lag_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          advance = 1'b0;
    logic [AW-1:0] src_base = '0;
    logic [AW-1:0] dst_base = '0;
    logic [31:0]   mode_word = '0;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [AW-1:0] m_sb, m_db, m_so, m_do;
    logic [31:0]   m_mode;

    lag_top #(.ADDR_W(AW)) dut (.*);

    always #10 clk = ~clk;

    function automatic logic [AW-1:0] step_off(input logic [AW-1:0] off,
                                               input logic hold,
                                               input logic [1:0] code);
        logic [AW-1:0] n;
        n = off + 1;
        if (hold) n = n % (AW'(1) << code);
        return n;
    endfunction

    function automatic logic [31:0] mk_mode(input logic sh, input logic [1:0] sc,
                                            input logic dh, input logic [1:0] dc);
        return (32'(sh) << 10) | (32'(dh) << 11) | (32'(sc) << 14) | (32'(dc) << 16);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [AW-1:0] got, input logic [AW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h expected=%h", req, what, got, exp);
        end
    endtask

    // drive at negedge, let one edge pass, check at the next negedge
    task automatic cyc(input string req, input logic st, input logic adv,
                       input logic [AW-1:0] sb, input logic [AW-1:0] db,
                       input logic [31:0] mw);
        start = st; advance = adv; src_base = sb; dst_base = db; mode_word = mw;
        if (st) begin
            m_sb = sb; m_db = db; m_mode = mw; m_so = '0; m_do = '0;
        end else if (adv) begin
            m_so = step_off(m_so, m_mode[10], m_mode[15:14]);
            m_do = step_off(m_do, m_mode[11], m_mode[17:16]);
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, "src", src_addr, m_sb + m_so);
        chk(req, "dst", dst_addr, m_db + m_do);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_sb = '0; m_db = '0; m_so = '0; m_do = '0; m_mode = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "src", src_addr, '0);
        chk("R1", "dst", dst_addr, '0);
        // R6: idle after reset
        cyc("R6", 0, 0, 32'h55, 32'h66, 32'hFFFF_FFFF);

        // R3: linear on both sides, R9 both step together
        cyc("R2", 1, 0, 32'h1000, 32'h2000, 32'h0);
        for (int i = 0; i < 5; i++) cyc("R3", 0, 1, 32'h0, 32'h0, 32'h0);
        // R3: wrap past the top of the address space
        cyc("R2", 1, 0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0);
        for (int i = 0; i < 3; i++) cyc("R3", 0, 1, 32'h0, 32'h0, 32'h0);

        // R4/R7: source window 4, destination linear
        cyc("R2", 1, 0, 32'h100, 32'h800, mk_mode(1, 2'd2, 0, 2'd0));
        for (int i = 0; i < 9; i++) cyc("R4", 0, 1, 32'h0, 32'h0, 32'h0);

        // R7: destination window 8, source window 2
        cyc("R2", 1, 0, 32'h3, 32'h7F, mk_mode(1, 2'd1, 1, 2'd3));
        for (int i = 0; i < 17; i++) cyc("R7", 0, 1, 32'h0, 32'h0, 32'h0);

        // R5: window of one pins both
        cyc("R2", 1, 0, 32'hABCD, 32'h1234, mk_mode(1, 2'd0, 1, 2'd0));
        for (int i = 0; i < 4; i++) cyc("R5", 0, 1, 32'h0, 32'h0, 32'h0);

        // R8: mode and base changes between starts are ignored
        cyc("R2", 1, 0, 32'h40, 32'h80, mk_mode(1, 2'd1, 0, 2'd0));
        for (int i = 0; i < 5; i++) cyc("R8", 0, 1, 32'h9999, 32'h7777, mk_mode(0, 2'd3, 1, 2'd0));

        // R2: start beats advance in the same cycle
        cyc("R2", 1, 1, 32'h500, 32'h600, mk_mode(0, 2'd0, 1, 2'd2));
        cyc("R6", 0, 0, 32'h0, 32'h0, 32'h0);
        cyc("R9", 0, 1, 32'h0, 32'h0, 32'h0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic st, adv;
            st  = ($urandom % 10) == 0;
            adv = ($urandom % 4) != 0;
            cyc("R4", st, adv, $urandom, $urandom,
                mk_mode($urandom % 2, 2'($urandom), $urandom % 2, 2'($urandom)));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule